// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block performs the memory side of a subroutine call or a subroutine return under a frame-pointer stack convention. A decode stage pulses a start strobe together with an operation code, the current program counter, the call target and the present stack pointer (SP) and frame pointer (FP). The sequencer then performs two word accesses through a request/acknowledge memory port and, after the last one is acknowledged, pulses done with the new SP, FP and next PC.

A call builds a three-word frame below SP: the highest word is a reserved static-chain slot that is never written, the middle word holds the return address and the lowest word holds the caller's FP. Both SP and FP then point at the lowest word. A return reads the saved FP and the return address relative to the current FP and rebuilds SP from FP, so whatever the callee left on the stack is discarded. Register file, decode and memory contents live outside this block.

Top module: `frame_seq`

## Requirements
- R1: While reset is asserted and after it is released, sp_o, fp_o and pc_o are zero and mem_req_o, done_o and busy_o are low until a start is accepted.
- R2: A call (op 0 = call with 32-bit immediate target, op 1 = call through a register) makes exactly two writes in this order: the return address to address SP−8, then the old FP to address SP−12; the word at SP−4 is never touched. Addresses wrap modulo 2^32.
- R3: The return address written is PC+6 for op 0 and PC+2 for op 1.
- R4: When a call finishes, sp_o and fp_o both equal SP−12 and pc_o equals the call target.
- R5: A return (op 2) makes exactly two reads in this order: address FP, then address FP+4; at completion fp_o is the word read from FP and pc_o the word read from FP+4.
- R6: When a return finishes, sp_o equals the old FP+12, independent of the SP input.
- R7: The memory port is byte-lane ordered: bits [8k+7:8k] of mem_wdata_o and mem_rdata_i carry the byte at address mem_addr_o+k, and words are big-endian, so the most significant byte of a value sits in bits [7:0].
- R8: A start strobe that arrives while busy_o is high is ignored; the operation in progress completes with the values captured when it was accepted.
- R9: done_o is high for exactly one cycle, the cycle after the edge at which the last access is acknowledged; sp_o, fp_o and pc_o change only in that cycle.
- R10: mem_req_o is low while idle; once raised it stays high with mem_addr_o, mem_we_o and mem_wdata_o stable until mem_ack_i is sampled high.
- R11: A start with the reserved op code 3 is ignored: no memory request, no done pulse, outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | 0 immediate call, 1 register call, 2 return, 3 reserved |
| pc_i | input | 32 | Address of the call or return instruction |
| target_i | input | 32 | Call destination |
| sp_i | input | 32 | Current stack pointer |
| fp_i | input | 32 | Current frame pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Byte address of the word accessed |
| mem_wdata_o | output | 32 | Write data, byte-lane ordered |
| mem_rdata_i | input | 32 | Read data, byte-lane ordered, valid with ack |
| mem_ack_i | input | 1 | Access completes at an edge where request and ack are high |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 32 | Updated stack pointer |
| fp_o | output | 32 | Updated frame pointer |
| pc_o | output | 32 | Next program counter |

## Verification
The bench drives calls whose SP lies near zero so the frame addresses and the return address wrap; a design computing offsets at a narrower width or with the wrong sign would write outside the expected words. Returns are run with an SP input unrelated to FP, which exposes a design that rebuilds SP from SP instead of FP. Start pulses with different operands are injected while memory is stalled, catching a design that re-latches its operands or restarts, and the byte-lane check catches a little-endian layout or a swapped read path.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
   typedef enum logic [1:0] {
      OP_CALL_IMM = 2'd0,
      OP_CALL_REG = 2'd1,
      OP_RETURN   = 2'd2,
      OP_RSVD     = 2'd3
   } frame_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_RA,
      ST_PUSH_FP,
      ST_POP_FP,
      ST_POP_PC
   } seq_state_e;
endpackage

// File: rtl/frame_seq_lane.sv
// Converts between a value and its byte-lane memory image.
module frame_seq_lane #(
   parameter int XLEN       = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [XLEN-1:0] din,
   output logic [XLEN-1:0] dout
);
   localparam int NBYTES = XLEN / 8;

   generate
      if (BIG_ENDIAN) begin : g_swap
         for (genvar k = 0; k < NBYTES; k++) begin : g_byte
            assign dout[8*k +: 8] = din[8*(NBYTES-1-k) +: 8];
         end
      end else begin : g_pass
         assign dout = din;
      end
   endgenerate
endmodule

// File: rtl/frame_seq_ctrl.sv
// Sequencing state machine: captures operands, walks the two accesses,
// commits SP/FP/PC together with the done pulse.
module frame_seq_ctrl
   import frame_seq_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] target_i,
   input  logic [XLEN-1:0] sp_i,
   input  logic [XLEN-1:0] fp_i,
   output logic            mem_req,
   output logic            mem_we,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wval,
   input  logic [XLEN-1:0] mem_rval,
   input  logic            mem_ack,
   output logic            busy,
   output logic            done,
   output logic [XLEN-1:0] sp_q,
   output logic [XLEN-1:0] fp_q,
   output logic [XLEN-1:0] pc_q
);
   localparam logic [XLEN-1:0] STEP     = XLEN'(XLEN / 8);
   localparam logic [XLEN-1:0] RA_IMM   = XLEN'(INSN_BYTES + XLEN / 8);
   localparam logic [XLEN-1:0] RA_REG   = XLEN'(INSN_BYTES);

   seq_state_e      state;
   logic [XLEN-1:0] ra_l, tgt_l, sp_l, fp_l, nfp_l;
   logic            xfer;

   assign xfer = mem_req && mem_ack;
   assign busy = (state != ST_IDLE);

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = '0;
      mem_wval = '0;
      unique case (state)
         ST_PUSH_RA: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = sp_l - 2*STEP; mem_wval = ra_l;
         end
         ST_PUSH_FP: begin
            mem_req = 1'b1; mem_we = 1'b1;
            mem_addr = sp_l - 3*STEP; mem_wval = fp_l;
         end
         ST_POP_FP: begin
            mem_req = 1'b1; mem_addr = fp_l;
         end
         ST_POP_PC: begin
            mem_req = 1'b1; mem_addr = fp_l + STEP;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
         ra_l  <= '0; tgt_l <= '0; sp_l <= '0; fp_l <= '0; nfp_l <= '0;
         sp_q  <= '0; fp_q  <= '0; pc_q <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i && frame_op_e'(op_i) != OP_RSVD) begin
                  tgt_l <= target_i;
                  sp_l  <= sp_i;
                  fp_l  <= fp_i;
                  ra_l  <= pc_i + ((frame_op_e'(op_i) == OP_CALL_IMM) ? RA_IMM : RA_REG);
                  state <= (frame_op_e'(op_i) == OP_RETURN) ? ST_POP_FP : ST_PUSH_RA;
               end
            end
            ST_PUSH_RA: if (xfer) state <= ST_PUSH_FP;
            ST_PUSH_FP: if (xfer) begin
               sp_q  <= sp_l - 3*STEP;
               fp_q  <= sp_l - 3*STEP;
               pc_q  <= tgt_l;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            ST_POP_FP: if (xfer) begin
               nfp_l <= mem_rval;
               state <= ST_POP_PC;
            end
            ST_POP_PC: if (xfer) begin
               sp_q  <= fp_l + 3*STEP;
               fp_q  <= nfp_l;
               pc_q  <= mem_rval;
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
   parameter int XLEN       = 32,
   parameter int INSN_BYTES = 2,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [1:0]      op_i,
   input  logic [XLEN-1:0] pc_i,
   input  logic [XLEN-1:0] target_i,
   input  logic [XLEN-1:0] sp_i,
   input  logic [XLEN-1:0] fp_i,
   output logic            mem_req_o,
   output logic            mem_we_o,
   output logic [XLEN-1:0] mem_addr_o,
   output logic [XLEN-1:0] mem_wdata_o,
   input  logic [XLEN-1:0] mem_rdata_i,
   input  logic            mem_ack_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [XLEN-1:0] sp_o,
   output logic [XLEN-1:0] fp_o,
   output logic [XLEN-1:0] pc_o
);
   generate
      if (XLEN % 8 != 0 || XLEN < 16) begin : g_bad_xlen
         $error("frame_seq: XLEN must be a multiple of 8 and at least 16");
      end
      if (INSN_BYTES < 1) begin : g_bad_insn
         $error("frame_seq: INSN_BYTES must be positive");
      end
   endgenerate

   logic [XLEN-1:0] wval, rval;

   frame_seq_ctrl #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op_i),
      .pc_i     (pc_i),
      .target_i (target_i),
      .sp_i     (sp_i),
      .fp_i     (fp_i),
      .mem_req  (mem_req_o),
      .mem_we   (mem_we_o),
      .mem_addr (mem_addr_o),
      .mem_wval (wval),
      .mem_rval (rval),
      .mem_ack  (mem_ack_i),
      .busy     (busy_o),
      .done     (done_o),
      .sp_q     (sp_o),
      .fp_q     (fp_o),
      .pc_q     (pc_o)
   );

   frame_seq_lane #(.XLEN(XLEN), .BIG_ENDIAN(BIG_ENDIAN)) u_wlane (
      .din  (wval),
      .dout (mem_wdata_o)
   );

   frame_seq_lane #(.XLEN(XLEN), .BIG_ENDIAN(BIG_ENDIAN)) u_rlane (
      .din  (mem_rdata_i),
      .dout (rval)
   );
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic [1:0]      op_i,
   input logic [XLEN-1:0] target_i,
   input logic [XLEN-1:0] sp_i,
   input logic [XLEN-1:0] fp_i,
   input logic            mem_req_o,
   input logic            mem_we_o,
   input logic [XLEN-1:0] mem_addr_o,
   input logic [XLEN-1:0] mem_wdata_o,
   input logic            mem_ack_i,
   input logic            busy_o,
   input logic            done_o,
   input logic [XLEN-1:0] sp_o,
   input logic [XLEN-1:0] fp_o,
   input logic [XLEN-1:0] pc_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

   logic [1:0]      c_op;
   logic [XLEN-1:0] c_tgt, c_sp, c_fp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_op <= 2'd0; c_tgt <= '0; c_sp <= '0; c_fp <= '0;
      end else if (start_i && !busy_o && op_i != 2'd3) begin
         c_op <= op_i; c_tgt <= target_i; c_sp <= sp_i; c_fp <= fp_i;
      end
   end

   AST_FIRST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) && c_op != 2'd2 |-> mem_req_o && mem_we_o && mem_addr_o == c_sp - 2*STEP); // R2
   AST_CALL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && c_op != 2'd2 |-> sp_o == c_sp - 3*STEP && fp_o == sp_o && pc_o == c_tgt); // R4
   AST_RET_SP: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && c_op == 2'd2 |-> sp_o == c_fp + 3*STEP); // R6
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(sp_o) && $stable(fp_o) && $stable(pc_o)); // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                  && $stable(mem_wdata_o)); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o); // R10
   AST_RSVD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && op_i == 2'd3 |=> !busy_o && !done_o); // R11
endmodule

bind frame_seq frame_seq_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] pc, tgt, sp, fp, mfp, mpc;
      logic [3:0]  lat;
      logic        inj;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 32'h0000_0100, 32'h0000_2000, 32'h0000_8000, 32'h0000_8100, 32'h0, 32'h0, 4'd0, 1'b0},
      '{2'd1, 32'h0000_1234, 32'h0000_0400, 32'h0000_7FF0, 32'h0000_8000, 32'h0, 32'h0, 4'd2, 1'b1},
      '{2'd2, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 32'h0000_7FE4, 32'h0000_8000, 32'h0000_1236, 4'd1, 1'b0},
      '{2'd2, 32'h0000_0000, 32'h0000_0000, 32'h5555_0000, 32'h0000_0010, 32'hDEAD_BEEF, 32'h0102_0304, 4'd3, 1'b1},
      '{2'd0, 32'hFFFF_FFFC, 32'h1234_5678, 32'h0000_0008, 32'hA5A5_A5A5, 32'h0, 32'h0, 4'd0, 1'b0},
      '{2'd1, 32'h0000_0040, 32'h0000_0ABC, 32'h0000_0000, 32'h1122_3344, 32'h0, 32'h0, 4'd1, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [31:0] pc_i = '0, target_i = '0, sp_i = '0, fp_i = '0;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_ack_i = 1'b0;
   logic        mem_req_o, mem_we_o, busy_o, done_o;
   logic [31:0] mem_addr_o, mem_wdata_o, sp_o, fp_o, pc_o;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frame_seq u_frame_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .pc_i(pc_i),
      .target_i(target_i), .sp_i(sp_i), .fp_i(fp_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
      .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o)
   );

   function automatic logic [31:0] bswap(input logic [31:0] v);
      return {v[7:0], v[15:8], v[23:16], v[31:24]};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input int idx);
      logic [31:0] a_addr [2];
      logic [31:0] a_data [2];
      logic        a_we   [2];
      logic [31:0] s_sp, s_fp, s_pc;
      logic [31:0] e_ra, e_addr0, e_addr1, e_d0, e_d1, e_sp, e_fp, e_pc;
      int n = 0, waited = 0, guard = 0;
      bit injected = 0, hold_ok = 1, is_call;
      is_call = (v.op != 2'd2);
      s_sp = sp_o; s_fp = fp_o; s_pc = pc_o;
      start_i = 1'b1; op_i = v.op; pc_i = v.pc; target_i = v.tgt; sp_i = v.sp; fp_i = v.fp;
      @(negedge clk);
      start_i = 1'b0;
      op_i = 2'd2; pc_i = 32'hBAD0_0000; target_i = 32'hBAD0_0001;
      sp_i = 32'hBAD0_0002; fp_i = 32'hBAD0_0003;
      forever begin
         mem_ack_i = 1'b0;
         start_i = 1'b0;
         if (done_o) break;
         if (guard++ > 60) begin
            chk("R9", $sformatf("vec%0d done never seen", idx), 32'd0, 32'd1);
            break;
         end
         if (sp_o !== s_sp || fp_o !== s_fp || pc_o !== s_pc) hold_ok = 0;
         if (mem_req_o) begin
            if (waited < int'(v.lat)) begin
               waited++;
               if (v.inj && !injected) begin start_i = 1'b1; injected = 1; end
            end else begin
               if (n < 2) begin
                  a_addr[n] = mem_addr_o; a_data[n] = mem_wdata_o; a_we[n] = mem_we_o;
               end
               if (mem_addr_o == v.fp)              mem_rdata_i = bswap(v.mfp);
               else if (mem_addr_o == v.fp + 32'd4) mem_rdata_i = bswap(v.mpc);
               else                                 mem_rdata_i = 32'h0;
               mem_ack_i = 1'b1;
               n++;
               waited = 0;
            end
         end
         @(negedge clk);
      end
      // expected values from the requirements
      e_ra = v.pc + ((v.op == 2'd0) ? 32'd6 : 32'd2);
      if (is_call) begin
         e_addr0 = v.sp - 32'd8;  e_addr1 = v.sp - 32'd12;
         e_d0 = bswap(e_ra);      e_d1 = bswap(v.fp);
         e_sp = v.sp - 32'd12;    e_fp = v.sp - 32'd12; e_pc = v.tgt;
      end else begin
         e_addr0 = v.fp;          e_addr1 = v.fp + 32'd4;
         e_d0 = 32'h0;            e_d1 = 32'h0;
         e_sp = v.fp + 32'd12;    e_fp = v.mfp;         e_pc = v.mpc;
      end
      chk(is_call ? "R2" : "R5", $sformatf("vec%0d access count", idx), n, 2);
      if (n >= 2) begin
         chk(is_call ? "R2" : "R5", $sformatf("vec%0d first address", idx), a_addr[0], e_addr0);
         chk(is_call ? "R2" : "R5", $sformatf("vec%0d second address", idx), a_addr[1], e_addr1);
         chk(is_call ? "R2" : "R5", $sformatf("vec%0d access direction", idx),
             {30'd0, a_we[0], a_we[1]}, is_call ? 32'd3 : 32'd0);
         if (is_call) begin
            chk("R3", $sformatf("vec%0d return address lanes", idx), a_data[0], e_d0);
            chk("R7", $sformatf("vec%0d lane0 holds ra MSB", idx), {24'd0, a_data[0][7:0]}, {24'd0, e_ra[31:24]});
            chk("R7", $sformatf("vec%0d saved fp lanes", idx), a_data[1], e_d1);
         end
      end
      chk(is_call ? "R4" : "R6", $sformatf("vec%0d sp_o", idx), sp_o, e_sp);
      chk(is_call ? "R4" : "R5", $sformatf("vec%0d fp_o", idx), fp_o, e_fp);
      chk(is_call ? "R4" : "R5", $sformatf("vec%0d pc_o", idx), pc_o, e_pc);
      chk("R9", $sformatf("vec%0d outputs held before done", idx), {31'd0, hold_ok}, 32'd1);
      if (v.inj)
         chk("R8", $sformatf("vec%0d start while busy injected", idx), {31'd0, injected}, 32'd1);
      @(negedge clk);
      chk("R9", $sformatf("vec%0d done one cycle wide", idx), {31'd0, done_o}, 32'd0);
      chk("R8", $sformatf("vec%0d idle after done", idx), {31'd0, busy_o}, 32'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "sp_o in reset", sp_o, 32'd0);
      chk("R1", "req/done/busy in reset", {29'd0, mem_req_o, done_o, busy_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "fp_o/pc_o after reset", fp_o | pc_o, 32'd0);
      chk("R1", "idle after reset", {29'd0, mem_req_o, done_o, busy_o}, 32'd0);

      for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

      // R11: reserved op has no effect
      begin
         logic [31:0] s_sp, s_fp, s_pc;
         bit saw = 0;
         s_sp = sp_o; s_fp = fp_o; s_pc = pc_o;
         start_i = 1'b1; op_i = 2'd3; sp_i = 32'h100; fp_i = 32'h200; target_i = 32'h300;
         @(negedge clk);
         start_i = 1'b0;
         for (int k = 0; k < 6; k++) begin
            if (mem_req_o || done_o || busy_o) saw = 1;
            @(negedge clk);
         end
         chk("R11", "reserved op activity", {31'd0, saw}, 32'd0);
         chk("R11", "reserved op outputs", sp_o ^ s_sp | fp_o ^ s_fp | pc_o ^ s_pc, 32'd0);
      end

      // back-to-back call after reset re-entry
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "reset clears outputs", sp_o | fp_o | pc_o, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec(VECS[0], 6);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule